// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the memory operand address for a machine with eight 32-bit address registers, eight 32-bit data registers and a program counter. The caller supplies an addressing mode, a base register number, an index register choice, the operand size and the displacement fields from the instruction extension words. It also supplies the register file contents and the instruction address. The unit returns the effective address, the 24-bit address that goes to the external bus, an alignment error flag and, for the auto-increment and auto-decrement modes, a new value for the base register with a write enable.

The address arithmetic is combinational. One register stage on the outputs gives a fixed latency of one clock. Each accepted request is marked by `valid_i` and comes back with `valid_o` on the next cycle. Register 7 is the stack pointer: a byte-sized auto step on it moves by two, so the stack stays word aligned.

Top module: `ea_gen`

## Requirements
- R1: Mode encoding is 0 indirect, 1 post-increment, 2 pre-decrement, 3 displacement, 4 indexed, 5 PC displacement, 6 PC indexed and 7 absolute. In indirect mode the address is the base register. In absolute mode it is `abs_i`.
- R2: Size encoding is 0 byte, 1 word and 2 long; code 3 behaves as long. In post-increment mode the address is the base register. The written-back value is the base plus 1, 2 or 4 for byte, word or long.
- R3: When the base register is 7 and the size is byte, post-increment and pre-decrement step by 2 instead of 1.
- R4: In pre-decrement mode the base is first reduced by the step. The reduced value is both the address and the written-back value.
- R5: Displacement mode adds the sign-extended `disp16_i` to the base register.
- R6: Indexed mode adds the sign-extended `disp8_i`, the base register and the index value. `idx_sel_i[3]`=1 picks address register `idx_sel_i[2:0]` and 0 picks the data register with that number.
- R7: With `idx_long_i`=0 the index is bits 15:0 of the chosen register, sign-extended. With 1 it is all 32 bits.
- R8: The PC modes use `pc_i`+2 in place of the base register. `pc_i` is the instruction address, and the +2 makes it the address of the extension word. They then add `disp16_i` (mode 5) or index plus `disp8_i` (mode 6).
- R9: `addr_err_o` is 1 when the size is word or long and bit 0 of the address is 1. It is 0 for byte accesses.
- R10: `upd_we_o` is 1 only for valid post-increment or pre-decrement requests without an address error. `upd_sel_o` then equals the base register number. When an error is flagged the write enable stays 0.
- R11: `addr_bus_o` carries bits 23:0 of the 32-bit effective address.
- R12: All outputs appear one clock after the request. While `rst_ni` is low they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| mode_i | input | 3 | Addressing mode |
| size_i | input | 2 | Operand size |
| base_sel_i | input | 3 | Base address register number |
| idx_sel_i | input | 4 | Index register: bit 3 selects address (1) or data (0) file |
| idx_long_i | input | 1 | Index uses all 32 bits |
| disp16_i | input | 16 | 16-bit signed displacement |
| disp8_i | input | 8 | 8-bit signed displacement |
| abs_i | input | 32 | Absolute address |
| pc_i | input | 32 | Instruction address |
| areg_i | input | 256 | Address registers, register k at bits 32k+31:32k |
| dreg_i | input | 256 | Data registers, same packing |
| valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Effective address |
| addr_bus_o | output | 24 | External address |
| addr_err_o | output | 1 | Misaligned word or long access |
| upd_we_o | output | 1 | Base register write enable |
| upd_sel_o | output | 3 | Register to write |
| upd_val_o | output | 32 | New base register value |

## Verification
Register files and displacements are random, with negative displacements and negative word indexes common. A wrong sign extension or a swapped index file therefore shows up as a wrong address. Directed cases separate the stack pointer's byte step from other registers, and a word index from a long index built on a register whose upper half differs from the sign fill. Odd bases used with each size separate the error flag and the suppressed write from the normal update. Addresses above 16 MB show that only the bus output is truncated.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    M_IND    = 3'd0,
    M_POSTINC = 3'd1,
    M_PREDEC = 3'd2,
    M_DISP   = 3'd3,
    M_INDEX  = 3'd4,
    M_PCDISP = 3'd5,
    M_PCIDX  = 3'd6,
    M_ABS    = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } ea_size_e;
endpackage

// File: rtl/ea_step.sv
module ea_step #(
  parameter int RW = 3,
  parameter int AW = 32
) (
  input  logic [1:0]    size_i,
  input  logic [RW-1:0] reg_i,
  output logic [AW-1:0] step_o
);
  localparam logic [RW-1:0] SP_REG = {RW{1'b1}};
  always_comb begin
    unique case (size_i)
      2'd0:    step_o = (reg_i == SP_REG) ? AW'(2) : AW'(1);
      2'd1:    step_o = AW'(2);
      default: step_o = AW'(4);
    endcase
  end
endmodule

// File: rtl/ea_index.sv
module ea_index #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [NREG*AW-1:0] areg_i,
  input  logic [NREG*AW-1:0] dreg_i,
  input  logic [RW:0]        sel_i,
  input  logic               long_i,
  output logic [AW-1:0]      idx_o
);
  logic [AW-1:0] raw;
  always_comb begin
    if (sel_i[RW]) raw = areg_i[sel_i[RW-1:0]*AW +: AW];
    else           raw = dreg_i[sel_i[RW-1:0]*AW +: AW];
    idx_o = long_i ? raw : {{(AW-16){raw[15]}}, raw[15:0]};
  end
endmodule

// File: rtl/ea_align.sv
module ea_align (
  input  logic [1:0] size_i,
  input  logic       lsb_i,
  output logic       err_o
);
  assign err_o = (size_i != 2'd0) && lsb_i;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int AW    = 32,
  parameter int BUS_W = 24,
  parameter int PC_EXT = 2,
  localparam int RW   = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         size_i,
  input  logic [RW-1:0]      base_sel_i,
  input  logic [RW:0]        idx_sel_i,
  input  logic               idx_long_i,
  input  logic [15:0]        disp16_i,
  input  logic [7:0]         disp8_i,
  input  logic [AW-1:0]      abs_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [NREG*AW-1:0] areg_i,
  input  logic [NREG*AW-1:0] dreg_i,
  output logic               valid_o,
  output logic [AW-1:0]      ea_o,
  output logic [BUS_W-1:0]   addr_bus_o,
  output logic               addr_err_o,
  output logic               upd_we_o,
  output logic [RW-1:0]      upd_sel_o,
  output logic [AW-1:0]      upd_val_o
);
  logic [AW-1:0] base, pc_ext, step, idx, d16, d8;
  logic [AW-1:0] ea_c, upd_c;
  logic          err_c, auto_c;
  ea_mode_e      mode;

  assign mode   = ea_mode_e'(mode_i);
  assign base   = areg_i[base_sel_i*AW +: AW];
  assign pc_ext = pc_i + AW'(PC_EXT);
  assign d16    = {{(AW-16){disp16_i[15]}}, disp16_i};
  assign d8     = {{(AW-8){disp8_i[7]}}, disp8_i};

  ea_step #(.RW(RW), .AW(AW)) u_step (
    .size_i(size_i), .reg_i(base_sel_i), .step_o(step)
  );

  ea_index #(.NREG(NREG), .AW(AW)) u_index (
    .areg_i(areg_i), .dreg_i(dreg_i), .sel_i(idx_sel_i),
    .long_i(idx_long_i), .idx_o(idx)
  );

  always_comb begin
    upd_c  = base;
    auto_c = 1'b0;
    unique case (mode)
      M_IND:     ea_c = base;
      M_POSTINC: begin ea_c = base; upd_c = base + step; auto_c = 1'b1; end
      M_PREDEC:  begin ea_c = base - step; upd_c = base - step; auto_c = 1'b1; end
      M_DISP:    ea_c = base + d16;
      M_INDEX:   ea_c = base + idx + d8;
      M_PCDISP:  ea_c = pc_ext + d16;
      M_PCIDX:   ea_c = pc_ext + idx + d8;
      M_ABS:     ea_c = abs_i;
      default:   ea_c = abs_i;
    endcase
  end

  ea_align u_align (.size_i(size_i), .lsb_i(ea_c[0]), .err_o(err_c));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      ea_o       <= '0;
      addr_bus_o <= '0;
      addr_err_o <= 1'b0;
      upd_we_o   <= 1'b0;
      upd_sel_o  <= '0;
      upd_val_o  <= '0;
    end else begin
      valid_o    <= valid_i;
      ea_o       <= ea_c;
      addr_bus_o <= ea_c[BUS_W-1:0];
      addr_err_o <= valid_i && err_c;
      upd_we_o   <= valid_i && auto_c && !err_c;
      upd_sel_o  <= base_sel_i;
      upd_val_o  <= upd_c;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 32,
  parameter int BUS_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic [AW-1:0]    ea_o,
  input logic [BUS_W-1:0] addr_bus_o,
  input logic             addr_err_o,
  input logic             upd_we_o,
  input logic [AW-1:0]    upd_val_o
);
  AST_WE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_we_o |-> !addr_err_o); // R10
  AST_ERR_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (ea_o[0] && valid_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!upd_we_o && !addr_err_o)); // R12
  AST_UPD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_we_o |-> ((upd_val_o == ea_o) || ((upd_val_o - ea_o) == AW'(1)) ||
                  ((upd_val_o - ea_o) == AW'(2)) || ((upd_val_o - ea_o) == AW'(4)))); // R2
  AST_BUS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_bus_o == ea_o[BUS_W-1:0])); // R11
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .BUS_W(BUS_W)) u_ea_gen_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_o(valid_o), .ea_o(ea_o),
  .addr_bus_o(addr_bus_o), .addr_err_o(addr_err_o),
  .upd_we_o(upd_we_o), .upd_val_o(upd_val_o)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [1:0] size_i = '0;
  logic [2:0] base_sel_i = '0;
  logic [3:0] idx_sel_i = '0;
  logic idx_long_i = 1'b0;
  logic [15:0] disp16_i = '0;
  logic [7:0] disp8_i = '0;
  logic [31:0] abs_i = '0, pc_i = '0;
  logic [31:0] ar [8];
  logic [31:0] dr [8];
  logic [255:0] areg_i, dreg_i;
  logic valid_o, addr_err_o, upd_we_o;
  logic [31:0] ea_o, upd_val_o;
  logic [23:0] addr_bus_o;
  logic [2:0] upd_sel_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      areg_i[k*32 +: 32] = ar[k];
      dreg_i[k*32 +: 32] = dr[k];
    end
  end

  ea_gen uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v); return {{16{v[15]}}, v}; endfunction
  function automatic logic [31:0] sx8(input logic [7:0] v); return {{24{v[7]}}, v}; endfunction

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5, 3'd6: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic run(input logic [2:0] m, input logic [1:0] sz, input logic [2:0] b,
                     input logic [3:0] ix, input bit il, input logic [15:0] d16,
                     input logic [7:0] d8, input string tag);
    logic [31:0] base, stp, idx, raw, ea, upd;
    bit err, we;
    mode_i = m; size_i = sz; base_sel_i = b; idx_sel_i = ix; idx_long_i = il;
    disp16_i = d16; disp8_i = d8; valid_i = 1'b1;
    base = ar[b];
    stp = (sz == 2'd0) ? ((b == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1 ? 32'd2 : 32'd4);
    raw = ix[3] ? ar[ix[2:0]] : dr[ix[2:0]];
    idx = il ? raw : sx16(raw[15:0]);
    upd = base;
    case (m)
      3'd0: ea = base;
      3'd1: begin ea = base; upd = base + stp; end
      3'd2: begin ea = base - stp; upd = ea; end
      3'd3: ea = base + sx16(d16);
      3'd4: ea = base + idx + sx8(d8);
      3'd5: ea = pc_i + 32'd2 + sx16(d16);
      3'd6: ea = pc_i + 32'd2 + idx + sx8(d8);
      default: ea = abs_i;
    endcase
    err = (sz != 2'd0) && ea[0];
    we = (m == 3'd1 || m == 3'd2) && !err;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    check(valid_o == 1'b1, "R12", 32'(valid_o), 32'd1);
    check(ea_o == ea, tag == "" ? mode_req(m) : tag, ea_o, ea);
    check(addr_bus_o == ea[23:0], "R11", 32'(addr_bus_o), {8'h0, ea[23:0]});
    check(addr_err_o == err, "R9", 32'(addr_err_o), 32'(err));
    check(upd_we_o == we, "R10", 32'(upd_we_o), 32'(we));
    if (we) begin
      check(upd_val_o == upd, tag == "" ? mode_req(m) : tag, upd_val_o, upd);
      check(upd_sel_o == b, "R10", 32'(upd_sel_o), 32'(b));
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin ar[k] = $urandom; dr[k] = $urandom; end
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(valid_o == 0 && ea_o == 0 && upd_we_o == 0 && addr_err_o == 0, "R12", ea_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 / R3 directed steps
    ar[3] = 32'h0000_1000; ar[7] = 32'h0000_2000;
    run(3'd1, 2'd0, 3'd3, 4'd0, 0, 16'h0, 8'h0, "R2");
    run(3'd1, 2'd1, 3'd3, 4'd0, 0, 16'h0, 8'h0, "R2");
    run(3'd1, 2'd2, 3'd3, 4'd0, 0, 16'h0, 8'h0, "R2");
    run(3'd1, 2'd0, 3'd7, 4'd0, 0, 16'h0, 8'h0, "R3");
    run(3'd2, 2'd0, 3'd7, 4'd0, 0, 16'h0, 8'h0, "R3");
    run(3'd2, 2'd2, 3'd3, 4'd0, 0, 16'h0, 8'h0, "R4");
    // R5 negative displacement
    run(3'd3, 2'd1, 3'd3, 4'd0, 0, 16'hFFFA, 8'h0, "R5");
    // R7 word vs long index, upper half differing from sign fill
    dr[2] = 32'h1234_8000; ar[5] = 32'h0001_0010;
    run(3'd4, 2'd1, 3'd3, 4'd2, 0, 16'h0, 8'hFE, "R7");
    run(3'd4, 2'd1, 3'd3, 4'd2, 1, 16'h0, 8'hFE, "R7");
    run(3'd4, 2'd2, 3'd3, 4'hD, 0, 16'h0, 8'h04, "R6");
    // R8 PC relative
    pc_i = 32'h0000_1000;
    run(3'd5, 2'd0, 3'd0, 4'd0, 0, 16'h0FFE, 8'h0, "R8");
    run(3'd6, 2'd1, 3'd0, 4'd2, 1, 16'h0, 8'h10, "R8");
    // R9 / R10 misaligned auto modes suppress write; byte not flagged
    ar[4] = 32'h0000_3001;
    run(3'd1, 2'd1, 3'd4, 4'd0, 0, 16'h0, 8'h0, "R10");
    run(3'd2, 2'd2, 3'd4, 4'd0, 0, 16'h0, 8'h0, "R10");
    run(3'd1, 2'd0, 3'd4, 4'd0, 0, 16'h0, 8'h0, "R9");
    // R11 high address
    abs_i = 32'hFF12_3456;
    run(3'd7, 2'd1, 3'd0, 4'd0, 0, 16'h0, 8'h0, "R11");
    // R1 indirect
    run(3'd0, 2'd2, 3'd5, 4'd0, 0, 16'h0, 8'h0, "R1");
    // random
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 8; k++) begin ar[k] = $urandom; dr[k] = $urandom; end
      pc_i = $urandom; abs_i = $urandom;
      run(3'($urandom), 2'($urandom), 3'($urandom), 4'($urandom), 1'($urandom),
          16'($urandom), 8'($urandom), "");
    end
    // R12 no request: quiet outputs
    @(posedge clk_i); @(negedge clk_i);
    check(valid_o == 0 && upd_we_o == 0 && addr_err_o == 0, "R12", 32'(valid_o), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule